// File: doc/BRIEF.md
# Strobe-Captured Packet FIFO Write Port

This block is the receiving end of an asynchronous byte-wide write interface. An external master drives a byte, a target select and an active-low write strobe. Every line is oversampled on a fast internal clock. When the strobe is released (its low-to-high transition), the byte on the bus at that moment goes into a synchronous FIFO at the current write location. The write location then advances by one. A separate active-low packet-end strobe closes the bytes written so far into a packet. A short packet is valid. A packet-end with nothing written produces an empty-packet marker.

A read-side valid/ready stream drains the stored bytes in order. It flags the final byte of each packet and never exposes bytes whose packet is still open. Full and empty flags are exported after a fixed, parameterised delay. A strobe that arrives while storage is full is discarded and latches a sticky overflow indication. Chip-select qualification can be removed at elaboration for masters that tie it active.

Top module: `sfwp_port`

## Requirements
- R1: A byte is stored only on the low-to-high transition of `wr_strobe_n`, using the value of `bus_data` sampled together with that transition. Bytes leave the read side in the order they were written.
- R2: With `USE_CS`=1, a write or packet-end transition is ignored unless `cs_n` is 0 when it is sampled.
- R3: A write or packet-end transition is ignored unless `sel_addr` equals `TARGET_ADDR` when it is sampled.
- R4: A low-to-high transition of `pkt_end_n` closes all bytes written since the previous close into one packet. The read side shows `out_last`=1 on that packet's final byte and 0 on the others, for any length from 1 to `DEPTH`. `out_data` is held while `out_valid`=1 and `out_ready`=0.
- R5: Bytes of a packet that is not yet closed are withheld: `out_valid` stays 0 while only such bytes are stored.
- R6: A packet-end with no bytes pending stores one entry that reads back with `out_zero`=1, `out_last`=1 and `out_data`=0. This entry takes one storage slot.
- R7: A write, or an empty-packet marker, that arrives while `DEPTH` slots are in use is dropped and sets `overflow`. Only reset clears `overflow`.
- R8: `flag_full` (all `DEPTH` slots in use, counting open-packet bytes and markers) and `flag_empty` (no slot in use) follow the internal occupancy `FLAG_LAT` clock cycles late. From the strobe's rising edge at the pin, the flags respond after `SYNC_STAGES`+1+`FLAG_LAT` clock edges.
- R9: After reset, `out_valid`=0, `flag_empty`=1, `flag_full`=0 and `overflow`=0.
- R10: A write and a packet-end that are recognised in the same sampling cycle store the byte first. The close then includes that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_strobe_n | input | 1 | Asynchronous write strobe, active low, captured on release |
| pkt_end_n | input | 1 | Asynchronous packet-close strobe, active low |
| cs_n | input | 1 | Chip select, active low |
| sel_addr | input | ADDR_W | Target select lines |
| bus_data | input | DATA_W | Write data bus |
| out_valid | output | 1 | Read-side entry available |
| out_ready | input | 1 | Read-side consumer accepts entry |
| out_data | output | DATA_W | Read-side byte |
| out_last | output | 1 | Entry ends a packet |
| out_zero | output | 1 | Entry is an empty-packet marker |
| flag_full | output | 1 | Delayed full indication |
| flag_empty | output | 1 | Delayed empty indication |
| overflow | output | 1 | Sticky dropped-write indication |

## Verification
The bench builds the port with `DEPTH`=4, `TARGET_ADDR`=2, `ADDR_W`=2, `SYNC_STAGES`=2, `FLAG_LAT`=2 and chip select enabled. With four slots, every packet length from empty to completely full can be swept, and the overflow boundary is one write away. The two-bit select and the chip-select line together give only eight combinations, so all of them are applied to both strobes. The short synchroniser and flag delay make the pin-to-flag latency a small count (five edges) that the bench measures exactly.

// File: rtl/sfwp_pkg.sv
package sfwp_pkg;
   // Storage action chosen each cycle by the port front end.
   typedef enum logic [2:0] {
      ACT_IDLE  = 3'd0,
      ACT_WRITE = 3'd1,
      ACT_CLOSE = 3'd2,
      ACT_ZLP   = 3'd3,
      ACT_DROP  = 3'd4
   } wr_act_e;
endpackage

// File: rtl/sfwp_sync.sv
// Multi-stage sampler for a vector of asynchronous lines.
module sfwp_sync #(
   parameter int             W      = 1,
   parameter int             STAGES = 2,
   parameter logic [W-1:0]   INIT   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= INIT;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sfwp_edge.sv
// Release detector for active-low strobes: pulses when a line goes 0 -> 1.
module sfwp_edge #(
   parameter int N = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   output logic [N-1:0] rise
);
   logic [N-1:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '1;
      else        prev <= lvl;
   end

   assign rise = lvl & ~prev;
endmodule

// File: rtl/sfwp_fdly.sv
// Fixed-latency pipeline for exported status flags.
module sfwp_fdly #(
   parameter int           LAT  = 2,
   parameter int           W    = 2,
   parameter logic [W-1:0] INIT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage [LAT];

   genvar g;
   generate
      for (g = 0; g < LAT; g++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stage[g] <= INIT;
            else if (g == 0) stage[g] <= d;
            else             stage[g] <= stage[(g == 0) ? 0 : g-1];
         end
      end
   endgenerate

   assign q = stage[LAT-1];
endmodule

// File: rtl/sfwp_store.sv
// Packet-aware circular storage: write, commit and read pointers.
module sfwp_store
   import sfwp_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   parameter int PW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  wr_act_e           act,
   input  logic [DATA_W-1:0] din,
   input  logic              pop,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_last,
   output logic              rd_zero,
   output logic              rd_avail,
   output logic              pending,
   output logic              full,
   output logic              empty,
   output logic [PW:0]       wptr_o
);
   logic [DATA_W-1:0] dmem [DEPTH];
   logic [DEPTH-1:0]  lastv;
   logic [DEPTH-1:0]  zlpv;
   logic [PW:0]       wptr, cptr, rptr, used, wprev;
   logic [PW-1:0]     widx, pidx, ridx;

   assign wprev = wptr - 1'b1;
   assign widx  = wptr[PW-1:0];
   assign pidx  = wprev[PW-1:0];
   assign ridx  = rptr[PW-1:0];
   assign used  = wptr - rptr;

   // Byte storage carries no reset; entries are written before they become visible.
   always_ff @(posedge clk) begin
      if (act == ACT_WRITE)    dmem[widx] <= din;
      else if (act == ACT_ZLP) dmem[widx] <= '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         cptr  <= '0;
         rptr  <= '0;
         lastv <= '0;
         zlpv  <= '0;
      end else begin
         unique case (act)
            ACT_WRITE: begin
               lastv[widx] <= 1'b0;
               zlpv[widx]  <= 1'b0;
               wptr        <= wptr + 1'b1;
            end
            ACT_CLOSE: begin
               lastv[pidx] <= 1'b1;
               cptr        <= wptr;
            end
            ACT_ZLP: begin
               lastv[widx] <= 1'b1;
               zlpv[widx]  <= 1'b1;
               wptr        <= wptr + 1'b1;
               cptr        <= wptr + 1'b1;
            end
            default: ;
         endcase
         if (pop) rptr <= rptr + 1'b1;
      end
   end

   assign rd_avail = (rptr != cptr);
   assign rd_data  = dmem[ridx];
   assign rd_last  = lastv[ridx];
   assign rd_zero  = zlpv[ridx];
   assign pending  = (wptr != cptr);
   assign full     = (used == DEPTH[PW:0]);
   assign empty    = (used == '0);
   assign wptr_o   = wptr;
endmodule

// File: rtl/sfwp_port.sv
// Asynchronous strobe write port feeding a packet FIFO with a stream reader.
module sfwp_port
   import sfwp_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 2,
   parameter int TARGET_ADDR = 0,
   parameter int DEPTH       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int FLAG_LAT    = 2,
   parameter bit USE_CS      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_strobe_n,
   input  logic              pkt_end_n,
   input  logic              cs_n,
   input  logic [ADDR_W-1:0] sel_addr,
   input  logic [DATA_W-1:0] bus_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_last,
   output logic              out_zero,
   output logic              flag_full,
   output logic              flag_empty,
   output logic              overflow
);
   localparam int PW   = $clog2(DEPTH);
   localparam int SW   = 3 + ADDR_W + DATA_W;
   localparam logic [SW-1:0] SINIT = {3'b111, {(ADDR_W + DATA_W){1'b0}}};

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("sfwp_port: DEPTH must be a power of two, at least 2");
      assert (SYNC_STAGES >= 2)
         else $error("sfwp_port: SYNC_STAGES must be at least 2");
      assert (FLAG_LAT >= 1 && FLAG_LAT <= 4)
         else $error("sfwp_port: FLAG_LAT must lie in 1..4");
      assert (TARGET_ADDR >= 0 && TARGET_ADDR < (1 << ADDR_W))
         else $error("sfwp_port: TARGET_ADDR outside select range");
      assert (DATA_W >= 1 && ADDR_W >= 1)
         else $error("sfwp_port: widths must be positive");
   end

   // Sample every pin through the same chain so data and select align with the strobes.
   logic [SW-1:0]     s_vec;
   logic              cs_s, pe_s, wr_s;
   logic [ADDR_W-1:0] adr_s;
   logic [DATA_W-1:0] dat_s;

   sfwp_sync #(.W(SW), .STAGES(SYNC_STAGES), .INIT(SINIT)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, pkt_end_n, wr_strobe_n, sel_addr, bus_data}),
      .q     (s_vec)
   );
   assign {cs_s, pe_s, wr_s, adr_s, dat_s} = s_vec;

   logic [1:0] rel;
   sfwp_edge #(.N(2)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   ({pe_s, wr_s}),
      .rise  (rel)
   );

   logic cs_ok;
   generate
      if (USE_CS) begin : g_cs
         assign cs_ok = ~cs_s;
      end else begin : g_nocs
         logic unused_cs;
         assign unused_cs = cs_s;
         assign cs_ok     = 1'b1;
      end
   endgenerate

   logic hit, wr_ev, pe_ev, pe_req, pe_hold;
   assign hit    = cs_ok && (adr_s == ADDR_W'(TARGET_ADDR));
   assign wr_ev  = rel[0] && hit;
   assign pe_ev  = rel[1] && hit;
   assign pe_req = pe_ev || pe_hold;

   logic              full_int, empty_int, pending, rd_avail, pop;
   logic [PW:0]       wptr;
   wr_act_e           act;

   // The write wins a same-cycle collision; the close is carried one cycle.
   always_comb begin
      act = ACT_IDLE;
      if (wr_ev)         act = full_int ? ACT_DROP : ACT_WRITE;
      else if (pe_req)   act = pending ? ACT_CLOSE : (full_int ? ACT_DROP : ACT_ZLP);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pe_hold  <= 1'b0;
         overflow <= 1'b0;
      end else begin
         pe_hold <= wr_ev && pe_req;
         if (act == ACT_DROP) overflow <= 1'b1;
      end
   end

   assign pop = out_valid && out_ready;

   sfwp_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PW(PW)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .act      (act),
      .din      (dat_s),
      .pop      (pop),
      .rd_data  (out_data),
      .rd_last  (out_last),
      .rd_zero  (out_zero),
      .rd_avail (rd_avail),
      .pending  (pending),
      .full     (full_int),
      .empty    (empty_int),
      .wptr_o   (wptr)
   );
   assign out_valid = rd_avail;

   sfwp_fdly #(.LAT(FLAG_LAT), .W(2), .INIT(2'b01)) u_fdly (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({full_int, empty_int}),
      .q     ({flag_full, flag_empty})
   );
endmodule

// File: rtl/sfwp_port_chk.sv
// Property checker attached to every sfwp_port instance.
module sfwp_port_chk #(
   parameter int DATA_W   = 8,
   parameter int PW       = 4,
   parameter int FLAG_LAT = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_ev,
   input logic              full_int,
   input logic [PW:0]       wptr,
   input logic              overflow,
   input logic              flag_full,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_data,
   input logic              out_last,
   input logic              out_zero
);
   logic [3:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         age <= '0;
      else if (age != 4'hF) age <= age + 1'b1;
   end

   assert_sticky_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

   assert_drop_sets_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ev && full_int) |=> overflow);

   assert_post_increment_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ev && !full_int) |=> (wptr == $past(wptr) + 1'b1));

   assert_zero_marker_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_zero) |-> (out_last && out_data == '0));

   assert_flag_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 4'(FLAG_LAT)) |-> (flag_full == $past(full_int, FLAG_LAT)));

   assert_hold_when_stalled_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
endmodule

bind sfwp_port sfwp_port_chk #(.DATA_W(DATA_W), .PW(PW), .FLAG_LAT(FLAG_LAT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_ev     (wr_ev),
   .full_int  (full_int),
   .wptr      (wptr),
   .overflow  (overflow),
   .flag_full (flag_full),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .out_last  (out_last),
   .out_zero  (out_zero)
);

// File: tb/sfwp_port_tb.sv
module sfwp_port_tb;
   localparam int DW = 8, AW = 2, TGT = 2, DEPTH = 4, SYNC = 2, FLAT = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_n = 1'b1, pe_n = 1'b1, cs_n = 1'b1, out_ready = 1'b0;
   logic [AW-1:0] adr = '0;
   logic [DW-1:0] dat = '0;
   logic out_valid, out_last, out_zero, flag_full, flag_empty, overflow;
   logic [DW-1:0] out_data;

   int total = 0, bad = 0;
   bit done = 1'b0;
   int pend_q[$];
   int exp_q[$];
   int occ = 0;
   bit ovf_exp = 1'b0;

   always #2 clk = ~clk;

   sfwp_port #(.DATA_W(DW), .ADDR_W(AW), .TARGET_ADDR(TGT), .DEPTH(DEPTH),
               .SYNC_STAGES(SYNC), .FLAG_LAT(FLAT), .USE_CS(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_strobe_n(wr_n), .pkt_end_n(pe_n), .cs_n(cs_n),
      .sel_addr(adr), .bus_data(dat), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_last(out_last), .out_zero(out_zero),
      .flag_full(flag_full), .flag_empty(flag_empty), .overflow(overflow));

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      idle(2); rst_n = 1'b1;
      pend_q.delete(); exp_q.delete(); occ = 0; ovf_exp = 1'b0;
      idle(2);
   endtask

   task automatic model_write(input int a, input int d, input bit c);
      if (c == 1'b0 && a == TGT) begin
         if (occ == DEPTH) ovf_exp = 1'b1;
         else begin pend_q.push_back(d); occ++; end
      end
   endtask

   task automatic model_close(input int a, input bit c);
      if (c == 1'b0 && a == TGT) begin
         if (pend_q.size() == 0) begin
            if (occ == DEPTH) ovf_exp = 1'b1;
            else begin exp_q.push_back(32'h300); occ++; end
         end else begin
            while (pend_q.size() > 0) begin
               int v = pend_q.pop_front();
               exp_q.push_back(pend_q.size() == 0 ? (v | 32'h100) : v);
            end
         end
      end
   endtask

   task automatic write_byte(input int a, input int d, input bit c);
      @(negedge clk);
      adr = AW'(a); dat = DW'(d); cs_n = c; wr_n = 1'b0;
      idle(3); wr_n = 1'b1;
      idle(4); cs_n = 1'b1;
      model_write(a, d, c);
   endtask

   task automatic pkt_end(input int a, input bit c);
      @(negedge clk);
      adr = AW'(a); cs_n = c; pe_n = 1'b0;
      idle(3); pe_n = 1'b1;
      idle(4); cs_n = 1'b1;
      model_close(a, c);
   endtask

   task automatic drain(input string req);
      while (exp_q.size() > 0) begin
         int e = exp_q.pop_front();
         @(negedge clk);
         check({req, " valid"}, int'(out_valid), 1);
         check({req, " entry"}, int'({out_zero, out_last, out_data}), e);
         out_ready = 1'b1;
         @(negedge clk);
         out_ready = 1'b0;
         occ--;
      end
      @(negedge clk);
      if (pend_q.size() > 0) check("R5 withheld after drain", int'(out_valid), 0);
   endtask

   task automatic check_flags(input string req);
      idle(8);
      check({req, " flag_empty"}, int'(flag_empty), int'(occ == 0));
      check({req, " flag_full"}, int'(flag_full), int'(occ == DEPTH));
      check({req, " overflow"}, int'(overflow), int'(ovf_exp));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: state out of reset
      check("R9 out_valid", int'(out_valid), 0);
      check("R9 flag_empty", int'(flag_empty), 1);
      check("R9 flag_full", int'(flag_full), 0);
      check("R9 overflow", int'(overflow), 0);

      // R8: pin-to-flag latency on the strobe release
      begin
         int k = 0;
         @(negedge clk);
         adr = AW'(TGT); dat = 8'hA5; cs_n = 1'b0; wr_n = 1'b0;
         idle(3); wr_n = 1'b1;
         while (flag_empty && k < 20) begin @(negedge clk); k++; end
         check("R8 empty latency", k, SYNC + 1 + FLAT);
         idle(3); cs_n = 1'b1;
         model_write(TGT, 8'hA5, 1'b0);
      end
      for (int i = 1; i < DEPTH; i++) write_byte(TGT, 8'hA5 + i, 1'b0);
      check_flags("R8 full with open packet");
      check("R5 open packet hidden", int'(out_valid), 0);
      pkt_end(TGT, 1'b0);
      drain("R4 full packet");
      check_flags("R8 after drain");

      // R1 R4 R5 R6: every packet length from empty to full
      for (int len = 0; len <= DEPTH; len++) begin
         for (int i = 0; i < len; i++) write_byte(TGT, len * 16 + i + 1, 1'b0);
         if (len > 0) check("R5 before close", int'(out_valid), 0);
         pkt_end(TGT, 1'b0);
         drain(len == 0 ? "R6 empty packet" : "R1 R4 packet");
         check_flags("R8 sweep");
      end

      // R2 R3: all select/chip-select combinations on both strobes
      for (int a = 0; a < 4; a++)
         for (int c = 0; c < 2; c++) write_byte(a, 8'h40 + a * 2 + c, c[0]);
      for (int a = 0; a < 4; a++)
         for (int c = 0; c < 2; c++) begin
            pkt_end(a, c[0]);
            if (exp_q.size() == 0)
               check(c == 1 ? "R2 close ignored" : "R3 close ignored", int'(out_valid), 0);
         end
      drain("R2 R3 single hit");
      check_flags("R3 flags");

      // R10: write and close released together
      @(negedge clk);
      adr = AW'(TGT); dat = 8'h77; cs_n = 1'b0; wr_n = 1'b0; pe_n = 1'b0;
      idle(3); wr_n = 1'b1; pe_n = 1'b1;
      idle(5); cs_n = 1'b1;
      model_write(TGT, 8'h77, 1'b0);
      model_close(TGT, 1'b0);
      drain("R10 collision");

      // R7: write beyond capacity, then an empty-packet marker while full
      for (int i = 0; i <= DEPTH; i++) write_byte(TGT, 8'h90 + i, 1'b0);
      check_flags("R7 overflow write");
      pkt_end(TGT, 1'b0);
      drain("R7 kept bytes");
      for (int i = 0; i < DEPTH; i++) begin
         write_byte(TGT, 8'hC0 + i, 1'b0);
         pkt_end(TGT, 1'b0);
      end
      pkt_end(TGT, 1'b0);
      check_flags("R7 marker dropped");
      drain("R7 single-byte packets");
      check("R7 still sticky", int'(overflow), 1);
      do_reset();
      check("R7 cleared by reset", int'(overflow), 0);
      check("R9 empty after reset", int'(flag_empty), 1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule